// File: doc/BRIEF.md
# Packed-BCD Add/Subtract Unit

This unit is the add-with-carry and subtract-with-borrow datapath of a small 8-bit accumulator processor. A request carries the accumulator value, the memory operand, the incoming carry, an operation select, a decimal-mode enable and a flag-policy select. The unit returns the result and the negative, overflow, zero and carry flags, with a one-cycle `done` pulse when they are valid. Addition always includes the carry: software clears the carry first when it wants a plain sum. Subtraction subtracts the inverted carry, so an incoming carry of 1 means that no borrow is pending.

In decimal mode each 4-bit digit of the operands and of the result holds a value from 0 to 9. Two flag policies are offered. The legacy policy finishes one cycle after the request. It takes negative, overflow and zero from the plain binary sum, and only the carry follows the decimal result. The corrected policy derives every flag from the decimal-adjusted result and spends one more cycle on it. A build parameter removes the decimal hardware altogether, and the unit then treats every request as binary.

Top module: `dec_addsub`

## Requirements
- R1: Synchronous active-low reset clears `done`, `res` and all four flags to 0.
- R2: Binary add (`op_sub`=0, decimal off) gives `res` = (A + M + Cin) mod 256 and `flag_c` = carry out of bit 7. `flag_n` = `res[7]` and `flag_z` = (`res`==0). `flag_v` is set when A and M have the same bit 7 and `res[7]` differs from it.
- R3: Binary subtract (`op_sub`=1) is A + (~M) + Cin. `flag_c`=1 means no borrow. The N, Z and V flags follow R2, with ~M in place of M.
- R4: Decimal add (`dec_en`=1, valid BCD inputs, digits packed high digit in bits 7:4) gives the BCD form of (A + M + Cin) mod 100. `flag_c`=1 when the decimal sum exceeds 99.
- R5: Decimal subtract gives the BCD form of (A − M − (1−Cin)) mod 100. `flag_c`=0 exactly when that difference is negative.
- R6: Legacy policy (`fix_flags`=0) with decimal on: N, V and Z are the R2/R3 binary values of the same operands, and C is the decimal carry.
- R7: Corrected policy (`fix_flags`=1) with decimal on: `flag_n` = `res[7]` and `flag_z` = (`res`==0). `flag_v` is the R2/R3 sign rule applied to the decimal result. C is the decimal carry.
- R8: `done` pulses one cycle after an accepted `start`. It pulses two cycles after when `fix_flags`=1 and decimal mode is active.
- R9: A `start` raised while a corrected decimal operation is in its second cycle is ignored. No extra `done` follows, and the outputs keep the first result.
- R10: With `HAS_DECIMAL`=0, `dec_en` has no effect. Every request completes as binary (R2/R3) in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, sampled with the operands |
| op_sub | input | 1 | 0 = add with carry, 1 = subtract with borrow |
| dec_en | input | 1 | Decimal (packed BCD) mode enable |
| fix_flags | input | 1 | 0 = legacy flag policy, 1 = corrected flag policy |
| c_in | input | 1 | Incoming carry |
| a_in | input | W | Accumulator operand |
| m_in | input | W | Memory operand |
| res | output | W | Result |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| done | output | 1 | One-cycle pulse: result and flags valid |

## Verification
A broken digit correction or digit carry shows up as a wrong tens digit or a wrong `flag_c` on the very `done` pulse of the affected operation. The decimal sweep exercises every digit pair, so each of these faults is visible. A corrupted or stuck second-cycle state appears within two cycles of a corrected request. `done` is then missing, late or doubled, or an ignored request leaks through into `res`. Swapping the legacy and corrected flag sources changes N, Z or V on many legacy decimal results, and those results are compared on the first cycle after the request.

// File: rtl/dec_addsub_pkg.sv
`timescale 1ns/1ps
// Shared constants for the packed-BCD add/subtract unit.
// Assumes one decimal digit occupies one 4-bit nibble.
package dec_addsub_pkg;
    localparam int unsigned   DIGIT_W   = 4;
    localparam logic [4:0]    DIGIT_MAX = 5'd9;
    localparam logic [4:0]    DIGIT_ADJ = 5'd6;
endpackage

// File: rtl/dec_addsub_bin.sv
`timescale 1ns/1ps
// Plain binary adder: sum and carry out of a + b + cin.
// Assumes the caller has already inverted b for a subtraction.
module dec_addsub_bin #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    // full-width addition with carry out
    always_comb begin
        {cout, sum} = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    end
endmodule

// File: rtl/dec_addsub_adj.sv
`timescale 1ns/1ps
// Digit-serial decimal adder/subtractor, one stage per 4-bit digit.
// Add: a digit above 9 is moved up by 6 and carries.
// Subtract: a digit that borrowed is moved down by 6.
// Assumes valid BCD operands; other inputs give a defined but meaningless result.
module dec_addsub_adj
    import dec_addsub_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] m,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         cout
);
    localparam int unsigned ND = W / DIGIT_W;

    // cy carries a digit carry for add and a digit borrow for subtract
    logic [ND:0] cy;

    assign cy[0] = sub ? ~cin : cin;
    assign cout  = sub ? ~cy[ND] : cy[ND];

    for (genvar gi = 0; gi < ND; gi++) begin : g_dig
        logic [4:0] t;
        logic       co;
        logic [3:0] ad;
        logic [3:0] md;

        assign ad = a[gi*DIGIT_W +: DIGIT_W];
        assign md = m[gi*DIGIT_W +: DIGIT_W];

        // per-digit sum or difference with decimal correction
        always_comb begin
            co = 1'b0;
            if (!sub) begin
                t = {1'b0, ad} + {1'b0, md} + {4'b0, cy[gi]};
                if (t > DIGIT_MAX) begin
                    t  = t + DIGIT_ADJ;
                    co = 1'b1;
                end
            end else begin
                t = {1'b0, ad} - {1'b0, md} - {4'b0, cy[gi]};
                if (t[4]) begin
                    t  = t - DIGIT_ADJ;
                    co = 1'b1;
                end
            end
            // R4/R5: valid input digits must give a valid output digit
            if (({1'b0, ad} <= DIGIT_MAX) && ({1'b0, md} <= DIGIT_MAX)) begin
                a_r4_digit_range: assert ({1'b0, t[3:0]} <= DIGIT_MAX)
                    else $error("decimal digit out of range");
            end
        end

        assign cy[gi+1]                 = co;
        assign res[gi*DIGIT_W +: DIGIT_W] = t[3:0];
    end
endmodule

// File: rtl/dec_addsub_flags.sv
`timescale 1ns/1ps
// Sign, zero and signed-overflow flags for a result, given the sign bits
// of both addends (the second one already inverted for subtract).
module dec_addsub_flags #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] r,
    input  logic         sa,
    input  logic         sb,
    output logic         n,
    output logic         z,
    output logic         v
);
    // flag derivation from the result value
    always_comb begin
        n = r[W-1];
        z = (r == '0);
        v = (sa == sb) && (r[W-1] != sa);
    end
endmodule

// File: rtl/dec_addsub.sv
`timescale 1ns/1ps
// Add-with-carry / subtract-with-borrow unit with optional packed-BCD mode.
// Legacy policy: one cycle; N/V/Z from the binary sum, C from the decimal result.
// Corrected policy in decimal mode: a second cycle derives every flag from the
// adjusted result. While that second cycle is pending a new start is ignored.
// Assumes start is a single-cycle request and the operands are valid with it.
module dec_addsub
    import dec_addsub_pkg::*;
#(
    parameter int unsigned W           = 8,
    parameter bit          HAS_DECIMAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         op_sub,
    input  logic         dec_en,
    input  logic         fix_flags,
    input  logic         c_in,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] m_in,
    output logic [W-1:0] res,
    output logic         flag_n,
    output logic         flag_v,
    output logic         flag_z,
    output logic         flag_c,
    output logic         done
);
    logic [W-1:0] bm;
    logic [W-1:0] bin_sum;
    logic         bin_c;
    logic [W-1:0] dec_res;
    logic         dec_c;
    logic         dec_act;
    logic         slow;
    logic         take;
    logic         pend_q;
    logic [W-1:0] hold_res;
    logic         hold_c;
    logic         hold_sa;
    logic         hold_sb;
    logic         fb_n, fb_z, fb_v;
    logic         fh_n, fh_z, fh_v;
    logic [W-1:0] fin_res;
    logic         fin_c;

    // request qualification and operand conditioning
    always_comb begin
        bm      = op_sub ? ~m_in : m_in;
        dec_act = HAS_DECIMAL && dec_en;
        slow    = fix_flags && dec_act;
        take    = start && !pend_q;
        fin_res = dec_act ? dec_res : bin_sum;
        fin_c   = dec_act ? dec_c : bin_c;
    end

    dec_addsub_bin #(.W(W)) u_bin (
        .a    (a_in),
        .b    (bm),
        .cin  (c_in),
        .sum  (bin_sum),
        .cout (bin_c)
    );

    if (HAS_DECIMAL) begin : g_dec
        dec_addsub_adj #(.W(W)) u_adj (
            .a    (a_in),
            .m    (m_in),
            .cin  (c_in),
            .sub  (op_sub),
            .res  (dec_res),
            .cout (dec_c)
        );
    end else begin : g_nodec
        assign dec_res = bin_sum;
        assign dec_c   = bin_c;
    end

    dec_addsub_flags #(.W(W)) u_fb (
        .r  (bin_sum),
        .sa (a_in[W-1]),
        .sb (bm[W-1]),
        .n  (fb_n),
        .z  (fb_z),
        .v  (fb_v)
    );

    dec_addsub_flags #(.W(W)) u_fh (
        .r  (hold_res),
        .sa (hold_sa),
        .sb (hold_sb),
        .n  (fh_n),
        .z  (fh_z),
        .v  (fh_v)
    );

    // result registers, second-cycle hold state and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res      <= '0;
            flag_n   <= 1'b0;
            flag_v   <= 1'b0;
            flag_z   <= 1'b0;
            flag_c   <= 1'b0;
            done     <= 1'b0;
            pend_q   <= 1'b0;
            hold_res <= '0;
            hold_c   <= 1'b0;
            hold_sa  <= 1'b0;
            hold_sb  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (pend_q) begin
                res    <= hold_res;
                flag_n <= fh_n;
                flag_v <= fh_v;
                flag_z <= fh_z;
                flag_c <= hold_c;
                done   <= 1'b1;
                pend_q <= 1'b0;
            end else if (take) begin
                if (slow) begin
                    hold_res <= fin_res;
                    hold_c   <= fin_c;
                    hold_sa  <= a_in[W-1];
                    hold_sb  <= bm[W-1];
                    pend_q   <= 1'b1;
                end else begin
                    res    <= fin_res;
                    flag_n <= fb_n;
                    flag_v <= fb_v;
                    flag_z <= fb_z;
                    flag_c <= fin_c;
                    done   <= 1'b1;
                end
            end
        end
    end

    // R1: first cycle after reset shows no completion
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !done);
    // R8: single-cycle requests complete on the next cycle
    a_r8_fast_done: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !pend_q && !slow) |=> done);
    // R8: corrected decimal requests enter the second cycle without completing
    a_r8_slow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !pend_q && slow) |=> (pend_q && !done));
    // R9: the second cycle always completes and never chains
    a_r9_pend_finishes: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |=> (done && !pend_q));
endmodule

// File: tb/sim_dec_addsub.sv
`timescale 1ns/1ps
module sim_dec_addsub;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       op_sub = 1'b0;
    logic       dec_en = 1'b0;
    logic       fix_flags = 1'b0;
    logic       c_in = 1'b0;
    logic [7:0] a_in = '0;
    logic [7:0] m_in = '0;
    logic [7:0] res0, res1;
    logic       n0, v0, z0, c0, done0;
    logic       n1, v1, z1, c1, done1;
    int         n_chk = 0;
    int         n_bad = 0;

    always #5 clk = ~clk;

    dec_addsub #(.W(8), .HAS_DECIMAL(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub), .dec_en(dec_en),
        .fix_flags(fix_flags), .c_in(c_in), .a_in(a_in), .m_in(m_in),
        .res(res0), .flag_n(n0), .flag_v(v0), .flag_z(z0), .flag_c(c0), .done(done0));

    dec_addsub #(.W(8), .HAS_DECIMAL(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub), .dec_en(dec_en),
        .fix_flags(fix_flags), .c_in(c_in), .a_in(a_in), .m_in(m_in),
        .res(res1), .flag_n(n1), .flag_v(v1), .flag_z(z1), .flag_c(c1), .done(done1));

    task automatic chk(input string tag, input logic [12:0] got, input logic [12:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) + (v % 10));
    endfunction

    // reference: {res, n, v, z, c}
    function automatic logic [11:0] ref_calc(input logic fx, input logic dc, input logic sb,
                                             input logic ci, input logic [7:0] a,
                                             input logic [7:0] m);
        logic [7:0] mm, br, r;
        logic [8:0] bs;
        logic       bv, dcar;
        int         va, vm, s;
        mm = sb ? ~m : m;
        bs = {1'b0, a} + {1'b0, mm} + {8'b0, ci};
        br = bs[7:0];
        bv = (a[7] == mm[7]) && (br[7] != a[7]);
        if (!dc) return {br, br[7], bv, br == 8'h00, bs[8]};
        va = int'(a[7:4]) * 10 + int'(a[3:0]);
        vm = int'(m[7:4]) * 10 + int'(m[3:0]);
        if (!sb) begin
            s = va + vm + int'(ci);
            dcar = (s > 99);
            s = s % 100;
        end else begin
            s = va - vm - (1 - int'(ci));
            dcar = (s >= 0);
            if (s < 0) s = s + 100;
        end
        r = to_bcd(s);
        if (!fx) return {r, br[7], bv, br == 8'h00, dcar};
        return {r, r[7], (a[7] == mm[7]) && (r[7] != a[7]), r == 8'h00, dcar};
    endfunction

    task automatic run_op(input logic fx, input logic dc, input logic sb, input logic ci,
                          input logic [7:0] a, input logic [7:0] m);
        logic [11:0] e0, e1;
        int          lat, elat;
        string       tag;
        e0   = ref_calc(fx, dc, sb, ci, a, m);
        e1   = ref_calc(1'b0, 1'b0, sb, ci, a, m);
        elat = (fx && dc) ? 2 : 1;
        if (!dc) tag = sb ? "R3" : "R2";
        else     tag = $sformatf("%s/%s", sb ? "R5" : "R4", fx ? "R7" : "R6");
        @(negedge clk);
        fix_flags = fx; dec_en = dc; op_sub = sb; c_in = ci; a_in = a; m_in = m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R10: decimal-less build answers in binary in one cycle
        chk(dc ? "R10" : tag, {done1, res1, n1, v1, z1, c1}, {1'b1, e1});
        lat = 1;
        while (!done0 && lat < 4) begin
            @(negedge clk);
            lat++;
        end
        chk("R8 latency", 13'(lat), 13'(elat));
        chk(tag, {1'b1, res0, n0, v0, z0, c0}, {1'b1, e0});
    endtask

    initial begin
        #1_900_000;
        n_bad++;
        $display("FAIL watchdog expired: got timeout exp completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state on both builds
        chk("R1", {done0, res0, n0, v0, z0, c0}, 13'h0);
        chk("R1", {done1, res1, n1, v1, z1, c1}, 13'h0);
        rst_n = 1'b1;

        // R2/R3 corners: signed overflow, zero with carry, borrow
        run_op(1'b0, 1'b0, 1'b0, 1'b0, 8'h7F, 8'h01);
        run_op(1'b0, 1'b0, 1'b1, 1'b1, 8'h80, 8'h01);
        run_op(1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 8'h00);
        run_op(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00);
        run_op(1'b1, 1'b0, 1'b1, 1'b1, 8'h50, 8'hB0);

        // R2/R3 binary sweep, both flag policies (no extra cycle in binary)
        for (int a = 0; a < 256; a += 5)
            for (int m = 0; m < 256; m += 7)
                for (int k = 0; k < 4; k++)
                    run_op(a[0], 1'b0, k[1], k[0], 8'(a), 8'(m));

        // R4/R5/R6: every BCD operand pair, both ops, both carries, legacy policy
        for (int a = 0; a < 100; a++)
            for (int m = 0; m < 100; m++)
                for (int k = 0; k < 4; k++)
                    run_op(1'b0, 1'b1, k[1], k[0], to_bcd(a), to_bcd(m));

        // R4/R5/R7: all A digits against a stride of M, corrected policy
        for (int a = 0; a < 100; a++)
            for (int m = 0; m < 100; m += 7)
                for (int k = 0; k < 4; k++)
                    run_op(1'b1, 1'b1, k[1], k[0], to_bcd(a), to_bcd(m));
        run_op(1'b1, 1'b1, 1'b0, 1'b1, 8'h99, 8'h99);
        run_op(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00);

        // R9: second start during the pending cycle is ignored
        @(negedge clk);
        fix_flags = 1'b1; dec_en = 1'b1; op_sub = 1'b0; c_in = 1'b0;
        a_in = 8'h45; m_in = 8'h38; start = 1'b1;
        @(negedge clk);
        a_in = 8'h11; m_in = 8'h22;
        @(negedge clk);
        start = 1'b0;
        chk("R9 first result", {done0, res0, 4'b0}, {1'b1, 8'h83, 4'b0});
        @(negedge clk);
        chk("R9 no extra done", {done0, res0, 4'b0}, {1'b0, 8'h83, 4'b0});
        @(negedge clk);
        chk("R9 still idle", {done0, res0, 4'b0}, {1'b0, 8'h83, 4'b0});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule